// File: doc/BRIEF.md
# 100 Mb/s Nibble-to-Code-Group Line Codec

This block sits between a media-independent nibble interface and the symbol stream of a 100 Mb/s physical coding sublayer. Its transmit half turns a nibble stream qualified by a frame-enable and an error-request input into 5-bit code groups. At the start of each frame it puts a two-group start delimiter in place of the first two nibbles. After the last nibble it appends a two-group end delimiter. Between frames it fills the line with the idle group, and it substitutes the halt group for any nibble flagged as an error.

The receive half takes aligned 5-bit groups and turns them back into nibbles with a data-valid and an error flag. It looks one group ahead so that a delimiter pair is recognised as a pair. The start pair comes out as two preamble nibbles. The end pair and idle close the frame. Illegal groups inside a frame raise the error flag. Activity outside a frame that is not a proper start pair is reported as a false carrier. Serialisation, line coding and symbol alignment are done elsewhere. Both halves share one clock and an active-low asynchronous reset.

Top module: `pcs_4b5b_codec`

## Requirements
- R1: While a frame is in its data phase and tx_er is low, each nibble is sent as its data group: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R2: Outside a frame tx_code carries the idle group 11111, and it does so from reset onward. tx_er has no effect while tx_en is low.
- R3: The first nibble time with tx_en high after idle sends 11000, and the second sends 10001. Both replace the nibbles that were presented.
- R4: A data-phase nibble with tx_er high is sent as the halt group 00100.
- R5: The first nibble time with tx_en low after a frame sends 01101, and the next sends 00111. Idle follows. Frames must be separated by at least two low nibble times.
- R6: The transmit path is registered: tx_code reflects the inputs of the previous clock, so the first delimiter group appears one clock after tx_en rises.
- R7: A received 11000 followed directly by 10001 starts a frame. Each of the two groups is delivered as nibble 0101 with rx_dv high. Receive latency is two clocks from a group at rx_code to its nibble at rxd.
- R8: A received data group inside a frame is delivered as its nibble (table of R1) with rx_dv high and rx_er low.
- R9: Inside a frame, 01101 followed directly by 00111 ends it. Both groups are delivered with rx_dv and rx_er low and rxd 0000.
- R10: Inside a frame, any group that is neither data nor a terminating pair (halt 00100, unused codes, a stray delimiter) gives rx_dv high, rx_er high and rxd 0000.
- R11: An idle group inside a frame ends it without error: rx_dv low, rx_er low, rxd 0000.
- R12: Outside a frame, an idle group gives rx_dv, rx_er and rxd all zero. Every other group that does not begin a valid start pair gives rx_dv low, rx_er high and rxd 1110.
- R13: During and after reset tx_code is 11111, and rx_dv, rx_er and rxd are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble-rate clock shared by both paths |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Frame enable for the transmit nibble stream |
| tx_er | input | 1 | Request to send the halt group in place of the current nibble |
| txd | input | 4 | Transmit nibble |
| tx_code | output | 5 | Transmit code group |
| rx_code | input | 5 | Aligned received code group |
| rxd | output | 4 | Received nibble |
| rx_dv | output | 1 | Received nibble belongs to a frame |
| rx_er | output | 1 | Received group was an error or a false carrier |

## Verification
The assertions check on every cycle the shape of the transmitted stream: every group is legal, each delimiter is followed by its partner, idle follows the end pair, the halt group follows an error request, and the start group comes one clock after a frame opens. They also check the receive flag encodings, which are the preamble after a detected start pair, two quiet cycles after a detected end pair, the false-carrier nibble and zeroed data on error. The exact nibble-to-group mapping, the round trip of whole frames through both halves, and the pairing decisions that depend on the following group (a start group not followed by its partner, an end group not followed by its partner, idle inside a frame) are only shown by the bench scenarios against its reference model.

// File: rtl/pcs_4b5b_pkg.sv
package pcs_4b5b_pkg;

  localparam int NIB_W = 4;
  localparam int GRP_W = 5;
  localparam int NUM_DATA = 1 << NIB_W;

  typedef logic [GRP_W-1:0] grp_t;
  typedef logic [NIB_W-1:0] nib_t;

  // control groups
  localparam grp_t GRP_IDLE  = 5'b11111;
  localparam grp_t GRP_SSD_J = 5'b11000;
  localparam grp_t GRP_SSD_K = 5'b10001;
  localparam grp_t GRP_ESD_T = 5'b01101;
  localparam grp_t GRP_ESD_R = 5'b00111;
  localparam grp_t GRP_HALT  = 5'b00100;

  // nibbles presented on the receive side
  localparam nib_t NIB_PREAMBLE = 4'b0101;
  localparam nib_t NIB_FALSECAR = 4'b1110;
  localparam nib_t NIB_ZERO     = 4'b0000;

  typedef enum logic [1:0] {
    TX_QUIET,  // idle fill between frames
    TX_LEAD,   // second start group pending
    TX_BODY,   // data nibbles
    TX_TAIL    // second end group pending
  } tx_state_e;

  typedef struct packed {
    logic ok;
    nib_t nib;
  } dec_t;

  function automatic grp_t nib_to_grp(nib_t n);
    grp_t g;
    unique case (n)
      4'h0: g = 5'b11110;
      4'h1: g = 5'b01001;
      4'h2: g = 5'b10100;
      4'h3: g = 5'b10101;
      4'h4: g = 5'b01010;
      4'h5: g = 5'b01011;
      4'h6: g = 5'b01110;
      4'h7: g = 5'b01111;
      4'h8: g = 5'b10010;
      4'h9: g = 5'b10011;
      4'hA: g = 5'b10110;
      4'hB: g = 5'b10111;
      4'hC: g = 5'b11010;
      4'hD: g = 5'b11011;
      4'hE: g = 5'b11100;
      default: g = 5'b11101;
    endcase
    return g;
  endfunction

  // reverse lookup computed from the forward table
  function automatic dec_t grp_to_nib(grp_t g);
    dec_t d;
    d.ok  = 1'b0;
    d.nib = NIB_ZERO;
    for (int i = 0; i < NUM_DATA; i++) begin
      if (nib_to_grp(nib_t'(i)) == g) begin
        d.ok  = 1'b1;
        d.nib = nib_t'(i);
      end
    end
    return d;
  endfunction

  function automatic logic grp_is_ctrl(grp_t g);
    return (g == GRP_IDLE) || (g == GRP_SSD_J) || (g == GRP_SSD_K) ||
           (g == GRP_ESD_T) || (g == GRP_ESD_R) || (g == GRP_HALT);
  endfunction

  function automatic logic grp_is_legal(grp_t g);
    dec_t d;
    d = grp_to_nib(g);
    return d.ok || grp_is_ctrl(g);
  endfunction

endpackage

// File: rtl/pcs_tx_framer.sv
module pcs_tx_framer
  import pcs_4b5b_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic tx_er,
  input  nib_t txd,
  output grp_t tx_code,
  output logic start_ev,
  output logic end_ev
);

  tx_state_e state_q, state_n;
  grp_t      code_q, code_n;

  always_comb begin
    state_n = state_q;
    code_n  = GRP_IDLE;
    unique case (state_q)
      TX_QUIET: begin
        if (tx_en) begin
          code_n  = GRP_SSD_J;
          state_n = TX_LEAD;
        end
      end
      TX_LEAD: begin
        if (tx_en) begin
          code_n  = GRP_SSD_K;
          state_n = TX_BODY;
        end else begin
          code_n  = GRP_ESD_T;
          state_n = TX_TAIL;
        end
      end
      TX_BODY: begin
        if (tx_en) begin
          code_n = tx_er ? GRP_HALT : nib_to_grp(txd);
        end else begin
          code_n  = GRP_ESD_T;
          state_n = TX_TAIL;
        end
      end
      TX_TAIL: begin
        code_n  = GRP_ESD_R;
        state_n = TX_QUIET;
      end
      default: begin
        code_n  = GRP_IDLE;
        state_n = TX_QUIET;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_QUIET;
      code_q  <= GRP_IDLE;
    end else begin
      state_q <= state_n;
      code_q  <= code_n;
    end
  end

  assign tx_code  = code_q;
  assign start_ev = (state_q == TX_QUIET) && tx_en;
  assign end_ev   = ((state_q == TX_LEAD) || (state_q == TX_BODY)) && !tx_en;

endmodule

// File: rtl/pcs_rx_deframer.sv
module pcs_rx_deframer
  import pcs_4b5b_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  grp_t rx_code,
  output nib_t rxd,
  output logic rx_dv,
  output logic rx_er,
  output logic start_hit,
  output logic end_hit,
  output logic fc_hit
);

  grp_t held_q;      // group under decision; rx_code is the look-ahead
  logic frame_q, frame_n;
  logic skip_q, skip_n;
  nib_t rxd_q, rxd_n;
  logic dv_q, dv_n;
  logic er_q, er_n;
  dec_t held_dec;

  assign held_dec = grp_to_nib(held_q);

  always_comb begin
    frame_n   = frame_q;
    skip_n    = 1'b0;
    rxd_n     = NIB_ZERO;
    dv_n      = 1'b0;
    er_n      = 1'b0;
    start_hit = 1'b0;
    end_hit   = 1'b0;
    fc_hit    = 1'b0;
    if (skip_q) begin
      // second group of a pair already accounted for
      if (frame_q) begin
        dv_n  = 1'b1;
        rxd_n = NIB_PREAMBLE;
      end
    end else if (!frame_q) begin
      if (held_q == GRP_IDLE) begin
        dv_n = 1'b0;
      end else if ((held_q == GRP_SSD_J) && (rx_code == GRP_SSD_K)) begin
        start_hit = 1'b1;
        frame_n   = 1'b1;
        skip_n    = 1'b1;
        dv_n      = 1'b1;
        rxd_n     = NIB_PREAMBLE;
      end else begin
        fc_hit = 1'b1;
        er_n   = 1'b1;
        rxd_n  = NIB_FALSECAR;
      end
    end else begin
      if (held_q == GRP_IDLE) begin
        frame_n = 1'b0;
      end else if ((held_q == GRP_ESD_T) && (rx_code == GRP_ESD_R)) begin
        end_hit = 1'b1;
        frame_n = 1'b0;
        skip_n  = 1'b1;
      end else if (held_dec.ok) begin
        dv_n  = 1'b1;
        rxd_n = held_dec.nib;
      end else begin
        dv_n = 1'b1;
        er_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= GRP_IDLE;
      frame_q <= 1'b0;
      skip_q  <= 1'b0;
      rxd_q   <= NIB_ZERO;
      dv_q    <= 1'b0;
      er_q    <= 1'b0;
    end else begin
      held_q  <= rx_code;
      frame_q <= frame_n;
      skip_q  <= skip_n;
      rxd_q   <= rxd_n;
      dv_q    <= dv_n;
      er_q    <= er_n;
    end
  end

  assign rxd   = rxd_q;
  assign rx_dv = dv_q;
  assign rx_er = er_q;

endmodule

// File: rtl/pcs_4b5b_codec.sv
module pcs_4b5b_codec
  import pcs_4b5b_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       tx_er,
  input  logic [3:0] txd,
  output logic [4:0] tx_code,
  input  logic [4:0] rx_code,
  output logic [3:0] rxd,
  output logic       rx_dv,
  output logic       rx_er
);

  logic tx_start_ev;
  logic tx_end_ev;
  logic rx_start_hit;
  logic rx_end_hit;
  logic rx_fc_hit;

  pcs_tx_framer u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .tx_er    (tx_er),
    .txd      (txd),
    .tx_code  (tx_code),
    .start_ev (tx_start_ev),
    .end_ev   (tx_end_ev)
  );

  pcs_rx_deframer u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_code   (rx_code),
    .rxd       (rxd),
    .rx_dv     (rx_dv),
    .rx_er     (rx_er),
    .start_hit (rx_start_hit),
    .end_hit   (rx_end_hit),
    .fc_hit    (rx_fc_hit)
  );

endmodule

// File: rtl/pcs_4b5b_checker.sv
module pcs_4b5b_checker
  import pcs_4b5b_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic       tx_er,
  input logic [4:0] tx_code,
  input logic [3:0] rxd,
  input logic       rx_dv,
  input logic       rx_er,
  input logic       tx_start,
  input logic       tx_end,
  input logic       rx_start,
  input logic       rx_end,
  input logic       rx_fc
);

  a_r1_legal_group: assert property (@(posedge clk) disable iff (!rst_n)
    grp_is_legal(tx_code));

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && tx_code == GRP_IDLE) |=> tx_code == GRP_IDLE);

  a_r3_start_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_code == GRP_SSD_J) |=> (tx_code == GRP_SSD_K || tx_code == GRP_ESD_T));

  a_r4_halt_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_er && tx_code != GRP_IDLE && tx_code != GRP_ESD_R &&
     tx_code != GRP_ESD_T && tx_code != GRP_SSD_J) |=> tx_code == GRP_HALT);

  a_r5_end_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_code == GRP_ESD_T) |=> tx_code == GRP_ESD_R);

  a_r5_idle_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_code == GRP_ESD_R) |=> (tx_code == GRP_IDLE || tx_code == GRP_SSD_J));

  a_r5_end_event: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |=> tx_code == GRP_ESD_T);

  a_r6_start_latency: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> tx_code == GRP_SSD_J);

  a_r7_preamble_pair: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start |=> (rx_dv && !rx_er && rxd == NIB_PREAMBLE) ##1
                 (rx_dv && !rx_er && rxd == NIB_PREAMBLE));

  a_r9_end_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end |=> (!rx_dv && !rx_er) ##1 (!rx_dv && !rx_er));

  a_r10_error_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dv && rx_er) |-> rxd == NIB_ZERO);

  a_r12_false_carrier: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fc |=> (!rx_dv && rx_er && rxd == NIB_FALSECAR));

  a_r12_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_dv && !rx_er) |-> rxd == NIB_ZERO);

endmodule

bind pcs_4b5b_codec pcs_4b5b_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_en    (tx_en),
  .tx_er    (tx_er),
  .tx_code  (tx_code),
  .rxd      (rxd),
  .rx_dv    (rx_dv),
  .rx_er    (rx_er),
  .tx_start (tx_start_ev),
  .tx_end   (tx_end_ev),
  .rx_start (rx_start_hit),
  .rx_end   (rx_end_hit),
  .rx_fc    (rx_fc_hit)
);

// File: tb/sim_pcs_4b5b_codec.sv
module sim_pcs_4b5b_codec;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic       loop_mode = 1'b1;
  logic [4:0] inj = 5'b11111;
  wire  [4:0] tx_code;
  wire  [3:0] rxd;
  wire        rx_dv;
  wire        rx_er;
  wire  [4:0] rx_bus = loop_mode ? tx_code : inj;

  always #2 clk = ~clk;  // 250 MHz

  pcs_4b5b_codec u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .tx_er   (tx_er),
    .txd     (txd),
    .tx_code (tx_code),
    .rx_code (rx_bus),
    .rxd     (rxd),
    .rx_dv   (rx_dv),
    .rx_er   (rx_er)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 0;
  int enc_tbl[16] = '{30, 9, 20, 21, 10, 11, 14, 15, 18, 19, 22, 23, 26, 27, 28, 29};

  // reference model state
  int    e_tx = 31, e_dv = 0, e_er = 0, e_rxd = 0;
  string tx_tag = "R13", rx_tag = "R13";
  int    m_pos = 0, m_tail = 0;
  int    r_prev = 31;
  bit    r_frame = 0, r_skip = 0;
  bit    collect = 0;
  int    got[$];

  task automatic check(string tag, int act, int exp, string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int dec_lookup(int g);
    for (int i = 0; i < 16; i++) if (enc_tbl[i] == g) return i;
    return -1;
  endfunction

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // compare every clock, then predict the next registered outputs
  always @(negedge clk) begin
    int c;
    int p;
    int dn;
    check(tx_tag, int'(tx_code), e_tx, "tx_code");
    check(rx_tag, int'(rx_dv), e_dv, "rx_dv");
    check(rx_tag, int'(rx_er), e_er, "rx_er");
    check(rx_tag, int'(rxd), e_rxd, "rxd");
    if (collect && rx_dv) got.push_back(int'(rxd));
    c = int'(rx_bus);
    p = r_prev;
    if (!rst_n) begin
      e_tx = 31; e_dv = 0; e_er = 0; e_rxd = 0;
      tx_tag = "R13"; rx_tag = "R13";
      m_pos = 0; m_tail = 0; r_prev = 31; r_frame = 0; r_skip = 0;
    end else begin
      // transmit: position within frame and count of low cycles after it
      if (tx_en) begin
        if (m_pos == 0) begin e_tx = 24; tx_tag = "R3/R6"; end
        else if (m_pos == 1) begin e_tx = 17; tx_tag = "R3"; end
        else if (tx_er) begin e_tx = 4; tx_tag = "R4"; end
        else begin e_tx = enc_tbl[txd]; tx_tag = "R1"; end
        m_pos++;
      end else if (m_pos > 0) begin
        e_tx = 13; tx_tag = "R5"; m_pos = 0; m_tail = 1;
      end else if (m_tail == 1) begin
        e_tx = 7; tx_tag = "R5"; m_tail = 0;
      end else begin
        e_tx = 31; tx_tag = "R2";
      end
      // receive: decide on previous group with current as look-ahead
      e_dv = 0; e_er = 0; e_rxd = 0;
      dn = dec_lookup(p);
      if (r_skip) begin
        r_skip = 0;
        if (r_frame) begin e_dv = 1; e_rxd = 5; rx_tag = "R7"; end
        else rx_tag = "R9";
      end else if (!r_frame) begin
        if (p == 31) rx_tag = "R12";
        else if (p == 24 && c == 17) begin
          e_dv = 1; e_rxd = 5; r_frame = 1; r_skip = 1; rx_tag = "R7";
        end else begin
          e_er = 1; e_rxd = 14; rx_tag = "R12";
        end
      end else begin
        if (p == 31) begin r_frame = 0; rx_tag = "R11"; end
        else if (p == 13 && c == 7) begin r_frame = 0; r_skip = 1; rx_tag = "R9"; end
        else if (dn >= 0) begin e_dv = 1; e_rxd = dn; rx_tag = "R8"; end
        else begin e_dv = 1; e_er = 1; rx_tag = "R10"; end
      end
      r_prev = c;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      report();
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic send(int nib[$], int err_idx);
    foreach (nib[i]) begin
      tx_en = 1'b1;
      txd   = 4'(nib[i]);
      tx_er = (i == err_idx);
      tick();
    end
    tx_en = 1'b0;
    tx_er = 1'b0;
    txd   = 4'h0;
    repeat (6) tick();
  endtask

  task automatic inject(int grp[$]);
    foreach (grp[i]) begin
      inj = 5'(grp[i]);
      tick();
    end
  endtask

  initial begin
    int fa[$];
    int fb[$];
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R13", int'(tx_code), 31, "reset tx_code");
    check("R13", int'(rx_dv), 0, "reset rx_dv");
    check("R13", int'(rx_er), 0, "reset rx_er");
    check("R13", int'(rxd), 0, "reset rxd");
    tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 R8: full table round trip through both halves
    fa = {5, 5, 5, 5, 5, 5, 5, 13};
    for (int i = 0; i < 16; i++) fa.push_back(i);
    fa.push_back(9); fa.push_back(6);
    collect = 1'b1;
    send(fa, -1);
    collect = 1'b0;
    check("R8", got.size(), fa.size(), "round-trip length");
    for (int i = 0; i < fa.size() && i < got.size(); i++)
      check("R8", got[i], fa[i], "round-trip nibble");

    // R2: tx_er while tx_en low is ignored
    tx_er = 1'b1; txd = 4'hA;
    repeat (4) tick();
    tx_er = 1'b0; txd = 4'h0;
    tick();

    // R4: halt group in the data phase
    fb = {5, 5, 5, 13, 3, 12, 7, 1};
    send(fb, 5);

    // R5: one-nibble and two-nibble frames
    send('{5}, -1);
    send('{5, 5}, -1);
    send('{5, 5, 8}, 2);

    // receive-side corner cases by direct injection
    loop_mode = 1'b0;
    inject('{31, 31, 24, 17, 21, 0, 15, 4, 13, 7, 31, 31});         // R8 R10 R9
    inject('{24, 17, 9, 31, 31, 31});                               // R11
    inject('{20, 31, 24, 31, 13, 7, 17, 31, 31, 31});               // R12
    inject('{24, 17, 13, 20, 24, 17, 2, 13, 7, 31, 31, 31, 31});    // R10 stray delimiters
    inject('{24, 24, 17, 30, 13, 7, 31, 31, 31});                   // R12 then R7
    loop_mode = 1'b1;
    repeat (4) tick();

    done = 1;
    report();
  end

endmodule